// File: doc/BRIEF.md
# Rotating Register Rename Unit

This block holds an integer register file and a predicate register file. It turns the logical register numbers that a software-pipelined loop uses into physical entry numbers. Each file has a low region that is never renamed and a high region that rotates. In the rotating region, a per-file base offset is added to the logical number modulo the size of the region. A loop-advance pulse steps both bases, so the physical entry that logical rN reached in one iteration is reached as rN+1 in the next. The highest logical number wraps to the lowest rotating number.

Each file has two combinational read ports and one write port. A write takes effect at the clock edge and is translated with the base in force before any advance in that cycle. A clear input returns both bases to zero and wins over an advance in the same cycle. Integer register 0 always reads zero and ignores writes.

Top module: `rrot_unit`

## Requirements
- R1: Integer logical register 0 reads as zero on both read ports, and a write to it changes no register.
- R2: Integer logical registers 1 to 31 and predicate logical registers 0 to 15 keep a fixed mapping, so advance and clear never change which value they read.
- R3: An integer value written to logical L in the range 32 to 127 is read at logical L+1 after one advance, and a value written at 127 is read at 32.
- R4: A predicate value written to logical L in the range 16 to 63 is read at logical L+1 after one advance, and a value written at 63 is read at 16.
- R5: Each advance steps the integer base down by one modulo 96 and the predicate base down by one modulo 48. After 96 (or 48) advances the mapping is back where it started.
- R6: A clear sets both bases to zero at the next edge and takes priority over an advance in the same cycle.
- R7: A write in the cycle of an advance uses the pre-advance base. A read is taken combinationally from the stored contents and does not show a write made in the same cycle.
- R8: After reset both bases are zero and every register reads zero.
- R9: The two read ports of each file work independently and may address any logical register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Loop-advance pulse, rotates both files by one |
| clr | input | 1 | Returns both rotating bases to zero |
| gr_ra_idx | input | 7 | Integer read port A logical number |
| gr_ra_data | output | 64 | Integer read port A data |
| gr_rb_idx | input | 7 | Integer read port B logical number |
| gr_rb_data | output | 64 | Integer read port B data |
| gr_we | input | 1 | Integer write enable |
| gr_wa_idx | input | 7 | Integer write logical number |
| gr_wd | input | 64 | Integer write data |
| pr_ra_idx | input | 6 | Predicate read port A logical number |
| pr_ra_data | output | 1 | Predicate read port A data |
| pr_rb_idx | input | 6 | Predicate read port B logical number |
| pr_rb_data | output | 1 | Predicate read port B data |
| pr_we | input | 1 | Predicate write enable |
| pr_wa_idx | input | 6 | Predicate write logical number |
| pr_wd | input | 1 | Predicate write data |

## Verification
The bench aims at the region edges, logical 31/32 and 127 for integers and 15/16 and 63 for predicates. A translation without the wrap would send the top register out of range or into the static region, and one with an off-by-one boundary would rotate register 31 or 15. It drives writes in advance cycles and clears together with advances. A design that used the post-advance base for writes would put data one place off, and one that let the advance win would leave the mapping shifted. It also writes register 0 and runs the base past its wrap point many times, which shows a lost zero or a base that runs past 95 or 47.

// File: rtl/rrot_unit.sv
module rrot_unit #(
  parameter int XLEN        = 64,
  parameter int INT_REGS    = 128,
  parameter int INT_STATIC  = 32,
  parameter int PRED_REGS   = 64,
  parameter int PRED_STATIC = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          adv,
  input  logic                          clr,
  input  logic [$clog2(INT_REGS)-1:0]   gr_ra_idx,
  output logic [XLEN-1:0]               gr_ra_data,
  input  logic [$clog2(INT_REGS)-1:0]   gr_rb_idx,
  output logic [XLEN-1:0]               gr_rb_data,
  input  logic                          gr_we,
  input  logic [$clog2(INT_REGS)-1:0]   gr_wa_idx,
  input  logic [XLEN-1:0]               gr_wd,
  input  logic [$clog2(PRED_REGS)-1:0]  pr_ra_idx,
  output logic                          pr_ra_data,
  input  logic [$clog2(PRED_REGS)-1:0]  pr_rb_idx,
  output logic                          pr_rb_data,
  input  logic                          pr_we,
  input  logic [$clog2(PRED_REGS)-1:0]  pr_wa_idx,
  input  logic                          pr_wd
);
  localparam int GIW      = $clog2(INT_REGS);
  localparam int INT_ROT  = INT_REGS - INT_STATIC;
  localparam int GBW      = $clog2(INT_ROT);
  localparam int PIW      = $clog2(PRED_REGS);
  localparam int PRED_ROT = PRED_REGS - PRED_STATIC;
  localparam int PBW      = $clog2(PRED_ROT);

  logic [XLEN-1:0] gr_q [INT_REGS];
  logic            pr_q [PRED_REGS];
  logic [GBW-1:0]  gb_q;
  logic [PBW-1:0]  pb_q;

  function automatic logic [GIW-1:0] gr_map(input logic [GIW-1:0] l, input logic [GBW-1:0] b);
    logic [GIW:0] off;
    if (l < GIW'(INT_STATIC)) return l;
    off = {1'b0, l} - (GIW+1)'(INT_STATIC) + (GIW+1)'(b);
    if (off >= (GIW+1)'(INT_ROT)) off = off - (GIW+1)'(INT_ROT);
    return GIW'(off + (GIW+1)'(INT_STATIC));
  endfunction

  function automatic logic [PIW-1:0] pr_map(input logic [PIW-1:0] l, input logic [PBW-1:0] b);
    logic [PIW:0] off;
    if (l < PIW'(PRED_STATIC)) return l;
    off = {1'b0, l} - (PIW+1)'(PRED_STATIC) + (PIW+1)'(b);
    if (off >= (PIW+1)'(PRED_ROT)) off = off - (PIW+1)'(PRED_ROT);
    return PIW'(off + (PIW+1)'(PRED_STATIC));
  endfunction

  assign gr_ra_data = (gr_ra_idx == '0) ? '0 : gr_q[gr_map(gr_ra_idx, gb_q)];
  assign gr_rb_data = (gr_rb_idx == '0) ? '0 : gr_q[gr_map(gr_rb_idx, gb_q)];
  assign pr_ra_data = pr_q[pr_map(pr_ra_idx, pb_q)];
  assign pr_rb_data = pr_q[pr_map(pr_rb_idx, pb_q)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gb_q <= '0;
      pb_q <= '0;
    end else if (clr) begin
      gb_q <= '0;
      pb_q <= '0;
    end else if (adv) begin
      gb_q <= (gb_q == '0) ? GBW'(INT_ROT - 1)  : gb_q - 1'b1;
      pb_q <= (pb_q == '0) ? PBW'(PRED_ROT - 1) : pb_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < INT_REGS; i++) gr_q[i] <= '0;
    end else if (gr_we && gr_wa_idx != '0) begin
      gr_q[gr_map(gr_wa_idx, gb_q)] <= gr_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PRED_REGS; i++) pr_q[i] <= 1'b0;
    end else if (pr_we) begin
      pr_q[pr_map(pr_wa_idx, pb_q)] <= pr_wd;
    end
  end
endmodule

// File: rtl/rrot_unit_chk.sv
module rrot_unit_chk #(
  parameter int XLEN        = 64,
  parameter int INT_REGS    = 128,
  parameter int INT_STATIC  = 32,
  parameter int PRED_REGS   = 64,
  parameter int PRED_STATIC = 16,
  parameter int GBW         = 7,
  parameter int PBW         = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         adv,
  input logic                         clr,
  input logic [$clog2(INT_REGS)-1:0]  gr_ra_idx,
  input logic [XLEN-1:0]              gr_ra_data,
  input logic [$clog2(INT_REGS)-1:0]  gr_rb_idx,
  input logic [XLEN-1:0]              gr_rb_data,
  input logic                         gr_we,
  input logic [$clog2(INT_REGS)-1:0]  gr_wa_idx,
  input logic [XLEN-1:0]              gr_wd,
  input logic [$clog2(PRED_REGS)-1:0] pr_ra_idx,
  input logic                         pr_ra_data,
  input logic                         pr_we,
  input logic [$clog2(PRED_REGS)-1:0] pr_wa_idx,
  input logic                         pr_wd,
  input logic [GBW-1:0]               gb_q,
  input logic [PBW-1:0]               pb_q
);
  localparam int GIW = $clog2(INT_REGS);
  localparam int PIW = $clog2(PRED_REGS);

  a_r1_gr0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_ra_idx == '0) |-> (gr_ra_data == '0));

  a_r2_static_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gr_we) && $past(gr_wa_idx) != '0 && $past(gr_wa_idx) < GIW'(INT_STATIC)
      && gr_rb_idx == $past(gr_wa_idx)) |-> (gr_rb_data == $past(gr_wd)));

  a_r3_int_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gr_we) && $past(adv) && !$past(clr) && $past(gr_wa_idx) >= GIW'(INT_STATIC)
      && gr_ra_idx == (($past(gr_wa_idx) == GIW'(INT_REGS - 1)) ? GIW'(INT_STATIC) : $past(gr_wa_idx) + 1'b1))
    |-> (gr_ra_data == $past(gr_wd)));

  a_r4_pred_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pr_we) && $past(adv) && !$past(clr) && $past(pr_wa_idx) >= PIW'(PRED_STATIC)
      && pr_ra_idx == (($past(pr_wa_idx) == PIW'(PRED_REGS - 1)) ? PIW'(PRED_STATIC) : $past(pr_wa_idx) + 1'b1))
    |-> (pr_ra_data == $past(pr_wd)));

  a_r5_base_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gb_q) < INT_REGS - INT_STATIC) && (int'(pb_q) < PRED_REGS - PRED_STATIC));

  a_r5_base_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (gb_q != $past(gb_q)) && (pb_q != $past(pb_q)));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (gb_q == '0) && (pb_q == '0));
endmodule

bind rrot_unit rrot_unit_chk #(
  .XLEN(XLEN), .INT_REGS(INT_REGS), .INT_STATIC(INT_STATIC),
  .PRED_REGS(PRED_REGS), .PRED_STATIC(PRED_STATIC), .GBW(GBW), .PBW(PBW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .clr(clr),
  .gr_ra_idx(gr_ra_idx), .gr_ra_data(gr_ra_data),
  .gr_rb_idx(gr_rb_idx), .gr_rb_data(gr_rb_data),
  .gr_we(gr_we), .gr_wa_idx(gr_wa_idx), .gr_wd(gr_wd),
  .pr_ra_idx(pr_ra_idx), .pr_ra_data(pr_ra_data),
  .pr_we(pr_we), .pr_wa_idx(pr_wa_idx), .pr_wd(pr_wd),
  .gb_q(gb_q), .pb_q(pb_q)
);

// File: tb/rrot_unit_bench.sv
module rrot_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 128, GS = 32, NP = 64, PS = 16;

  logic clk = 1'b0, rst_n = 1'b0, adv = 1'b0, clr = 1'b0;
  logic [6:0] gr_ra_idx = '0, gr_rb_idx = '0, gr_wa_idx = '0;
  logic [63:0] gr_ra_data, gr_rb_data, gr_wd = '0;
  logic gr_we = 1'b0;
  logic [5:0] pr_ra_idx = '0, pr_rb_idx = '0, pr_wa_idx = '0;
  logic pr_ra_data, pr_rb_data, pr_we = 1'b0, pr_wd = 1'b0;

  int compared = 0, mismatched = 0;
  logic [63:0] m_gr [NG];
  bit m_pr [NP];
  int shifts = 0;
  bit last_adv = 0, last_clr = 0, last_we = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rrot_unit u_rrot_unit (
    .clk(clk), .rst_n(rst_n), .adv(adv), .clr(clr),
    .gr_ra_idx(gr_ra_idx), .gr_ra_data(gr_ra_data),
    .gr_rb_idx(gr_rb_idx), .gr_rb_data(gr_rb_data),
    .gr_we(gr_we), .gr_wa_idx(gr_wa_idx), .gr_wd(gr_wd),
    .pr_ra_idx(pr_ra_idx), .pr_ra_data(pr_ra_data),
    .pr_rb_idx(pr_rb_idx), .pr_rb_data(pr_rb_data),
    .pr_we(pr_we), .pr_wa_idx(pr_wa_idx), .pr_wd(pr_wd));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string gtag(input int idx);
    if (idx == 0) return "R1";
    if (last_clr) return "R6";
    if (last_adv && last_we) return "R7";
    if (last_adv) return "R5";
    if (idx < GS) return "R2";
    return "R3";
  endfunction

  function automatic string ptag(input int idx);
    if (last_clr) return "R6";
    if (last_adv && last_we) return "R7";
    if (idx < PS) return "R2";
    return "R4";
  endfunction

  task automatic rot_fwd();
    logic [63:0] tg = m_gr[NG-1];
    bit tp = m_pr[NP-1];
    for (int i = NG-1; i > GS; i--) m_gr[i] = m_gr[i-1];
    m_gr[GS] = tg;
    for (int i = NP-1; i > PS; i--) m_pr[i] = m_pr[i-1];
    m_pr[PS] = tp;
  endtask

  task automatic rot_back();
    logic [63:0] tg = m_gr[GS];
    bit tp = m_pr[PS];
    for (int i = GS; i < NG-1; i++) m_gr[i] = m_gr[i+1];
    m_gr[NG-1] = tg;
    for (int i = PS; i < NP-1; i++) m_pr[i] = m_pr[i+1];
    m_pr[NP-1] = tp;
  endtask

  function automatic logic [6:0] pick_g();
    case ($urandom % 8)
      0: return 7'd0;
      1: return 7'd31;
      2: return 7'd32;
      3: return 7'd127;
      default: return 7'($urandom % NG);
    endcase
  endfunction

  function automatic logic [5:0] pick_p();
    case ($urandom % 8)
      0: return 6'd15;
      1: return 6'd16;
      2: return 6'd63;
      default: return 6'($urandom % NP);
    endcase
  endfunction

  task automatic compare_all();
    chk({"R9/", gtag(int'(gr_ra_idx))}, gr_ra_data, m_gr[gr_ra_idx]);
    chk({"R9/", gtag(int'(gr_rb_idx))}, gr_rb_data, m_gr[gr_rb_idx]);
    chk({"R9/", ptag(int'(pr_ra_idx))}, 64'(pr_ra_data), 64'(m_pr[pr_ra_idx]));
    chk({"R9/", ptag(int'(pr_rb_idx))}, 64'(pr_rb_data), 64'(m_pr[pr_rb_idx]));
  endtask

  task automatic update_model();
    if (gr_we && gr_wa_idx != 0) m_gr[gr_wa_idx] = gr_wd;
    if (pr_we) m_pr[pr_wa_idx] = pr_wd;
    if (clr) begin
      for (int k = 0; k < shifts; k++) rot_back();
      shifts = 0;
    end else if (adv) begin
      rot_fwd();
      shifts = (shifts + 1) % (NG - GS);
    end
    last_adv = adv; last_clr = clr; last_we = gr_we | pr_we;
  endtask

  task automatic step(input int p_adv, input int p_clr);
    @(negedge clk);
    adv = (($urandom % 100) < p_adv);
    clr = (($urandom % 1000) < p_clr);
    gr_we = ($urandom % 4) != 0;
    gr_wa_idx = pick_g();
    gr_wd = {$urandom, $urandom};
    pr_we = ($urandom % 3) != 0;
    pr_wa_idx = pick_p();
    pr_wd = 1'($urandom);
    gr_ra_idx = (last_adv && ($urandom % 2)) ? pick_g() : pick_g();
    gr_rb_idx = pick_g();
    pr_ra_idx = pick_p();
    pr_rb_idx = pick_p();
    #1 compare_all();
    @(posedge clk);
    update_model();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < NG; i++) m_gr[i] = '0;
    for (int i = 0; i < NP; i++) m_pr[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state, every register zero
    for (int i = 0; i < NG; i++) begin
      gr_ra_idx = 7'(i); gr_rb_idx = 7'(NG-1-i);
      pr_ra_idx = 6'(i % NP); pr_rb_idx = 6'((NP-1) - (i % NP));
      #1;
      chk("R8", gr_ra_data, 64'd0);
      chk("R8", gr_rb_data, 64'd0);
      chk("R8", 64'(pr_ra_data), 64'd0);
    end
    // R7: write and advance in the same cycle, read next logical afterwards
    @(negedge clk);
    gr_we = 1; gr_wa_idx = 7'd127; gr_wd = 64'hDEAD_BEEF_0123_4567;
    pr_we = 1; pr_wa_idx = 6'd63; pr_wd = 1'b1; adv = 1;
    gr_ra_idx = 7'd127; #1;
    chk("R7", gr_ra_data, 64'd0);
    @(posedge clk); update_model();
    @(negedge clk);
    gr_we = 0; pr_we = 0; adv = 0;
    gr_ra_idx = 7'd32; pr_ra_idx = 6'd16; #1;
    chk("R3", gr_ra_data, 64'hDEAD_BEEF_0123_4567);
    chk("R4", 64'(pr_ra_data), 64'd1);
    // R6: clear together with advance restores the original mapping
    adv = 1; clr = 1; #1;
    @(posedge clk); update_model();
    @(negedge clk);
    adv = 0; clr = 0; gr_ra_idx = 7'd127; pr_ra_idx = 6'd63; #1;
    chk("R6", gr_ra_data, 64'hDEAD_BEEF_0123_4567);
    chk("R6", 64'(pr_ra_data), 64'd1);
    @(posedge clk); update_model();
    // R5: long advance runs with no clear, base wraps many times
    repeat (2000) step(60, 0);
    // mixed traffic with clears
    repeat (3000) step(25, 20);
    repeat (1000) step(90, 100);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule